// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block is the instruction-fetch and branch-steering front end of a five-stage in-order pipeline. It owns the program counter, chooses the next fetch address, and decides conditional branches (equal and not-equal) while the branch sits in the decode stage. It compares the two register operand values that the surrounding datapath returns for the indices it presents. It adds a sign-extended word offset to the address that follows the branch. It discards the wrongly fetched instruction when the prediction that every branch falls through turns out wrong.

A build-time parameter selects one of three branch policies. In squash mode a taken branch flushes the single sequentially fetched instruction. In delayed mode the instruction right after a branch always runs. In late-resolve mode the decision is held back until the branch reaches execute, which costs two empty slots on every branch and serves as a timing baseline. A one-cycle interlock covers a branch whose operand is written by the instruction immediately ahead of it. Non-branch instructions travel through execute, memory and write-back unchanged, and so do branches. Every surviving instruction leaves through a retire port in program order.

Top module: `brfe_top`

## Requirements
- R1: While `rst_n` is low, `imem_addr` equals `RESET_PC`, `ret_valid` is low and `rs_idx`/`rt_idx` are zero.
- R2: An instruction whose bits [31:26] are 6'h04 is branch-if-equal and 6'h05 is branch-if-not-equal. It compares register bits [25:21] with register bits [20:16]. Its target is its own address + 4 + (sign-extended bits [15:0] shifted left by 2), and negative offsets move backwards.
- R3: Without branches the fetch address rises by 4 every cycle, and instructions retire in program order, one per cycle.
- R4: In squash mode a taken branch redirects fetch to its target on the next cycle and discards the one instruction fetched after it. Exactly one empty retire slot follows the branch, and `squash` is high in the cycle the branch resolves.
- R5: In squash mode a not-taken branch costs no cycle, and the next sequential instruction retires right after it.
- R6: In delayed mode the instruction after a branch always retires, whether or not the branch is taken. Fetch then continues at the target or at branch+8. No empty slot is added and `squash` never rises.
- R7: In late-resolve mode every branch, taken or not, is followed by exactly two empty retire slots.
- R8: A branch whose rs or rt field equals a nonzero destination of the instruction directly ahead waits one cycle in decode (`hold` high, fetch address unchanged) and then adds exactly one empty slot. The destination is bits [15:11] for opcode 6'h00 and bits [20:16] for opcode 6'h08. `hold` never stays high two cycles in a row.
- R9: An instruction retires on `ret_valid`/`ret_pc`/`ret_instr` three cycles after it leaves decode, and the first instruction after reset retires in the fourth cycle. Branches retire as well, and discarded instructions never retire.
- R10: `rs_idx`/`rt_idx` always show bits [25:21]/[20:16] of the instruction currently held in decode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Fetch address (PC register) |
| imem_data | input | 32 | Instruction word read combinationally at `imem_addr` |
| rs_idx | output | 5 | First operand register index of the decode-stage instruction |
| rt_idx | output | 5 | Second operand register index of the decode-stage instruction |
| rs_val | input | 32 | Value of register `rs_idx` |
| rt_val | input | 32 | Value of register `rt_idx` |
| squash | output | 1 | High when a fetched instruction is being discarded |
| hold | output | 1 | High during a one-cycle operand interlock |
| ret_valid | output | 1 | An instruction retires this cycle |
| ret_pc | output | 32 | Address of the retiring instruction |
| ret_instr | output | 32 | Word of the retiring instruction |

## Verification
A wrong PC or redirect shows up on `imem_addr` on the next cycle. Three cycles later it shows up on the retire port as a skipped, extra or out-of-order address. A missed or spurious flush changes the retire sequence: a delay-slot instruction that should have been discarded, or a missing one. A broken interlock or late-resolve counter shifts the retire cycle of the branch and of every later instruction by one or more cycles. This is caught by comparing exact retire cycles against a cycle-count model derived from the requirements.

// File: rtl/brfe_pkg.sv
`timescale 1ns/1ps
package brfe_pkg;

    localparam int ILEN   = 32;
    localparam int XLEN   = 32;
    localparam int PC_W   = 32;
    localparam int RIDX_W = 5;
    localparam int OP_W   = 6;
    localparam int OFF_W  = 16;

    localparam int OP_LSB = ILEN - OP_W;
    localparam int RS_LSB = OP_LSB - RIDX_W;
    localparam int RT_LSB = RS_LSB - RIDX_W;
    localparam int RD_LSB = RT_LSB - RIDX_W;

    localparam logic [OP_W-1:0] OP_ALU = 6'h00;
    localparam logic [OP_W-1:0] OP_BEQ = 6'h04;
    localparam logic [OP_W-1:0] OP_BNE = 6'h05;
    localparam logic [OP_W-1:0] OP_IMM = 6'h08;

    typedef enum logic [1:0] {
        MODE_FLUSH = 2'd0,
        MODE_DELAY = 2'd1,
        MODE_EXEC  = 2'd2
    } br_mode_e;

    typedef struct packed {
        logic             valid;
        logic [PC_W-1:0]  pc;
        logic [ILEN-1:0]  instr;
    } slot_t;

    typedef struct packed {
        logic             valid;
        logic [PC_W-1:0]  pc;
        logic [ILEN-1:0]  instr;
        logic             is_br;
        logic             taken;
        logic [PC_W-1:0]  target;
    } br_slot_t;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        slot_t           ifid;
        br_slot_t        idex;
        slot_t           exmem;
        slot_t           memwb;
    } fe_state_t;

    // Destination register written by an instruction, zero when none.
    function automatic logic [RIDX_W-1:0] dest_reg(input logic [ILEN-1:0] instr);
        logic [OP_W-1:0] op;
        op = instr[OP_LSB +: OP_W];
        if (op == OP_ALU)      return instr[RD_LSB +: RIDX_W];
        else if (op == OP_IMM) return instr[RT_LSB +: RIDX_W];
        else                   return '0;
    endfunction

endpackage

// File: rtl/brfe_decode.sv
`timescale 1ns/1ps
module brfe_decode
    import brfe_pkg::*;
(
    input  logic [ILEN-1:0]   instr,
    output logic              is_br,
    output logic              is_bne,
    output logic [RIDX_W-1:0] rs,
    output logic [RIDX_W-1:0] rt,
    output logic [OFF_W-1:0]  offset
);
    logic [OP_W-1:0] op;

    always_comb begin
        op     = instr[OP_LSB +: OP_W];
        is_br  = (op == OP_BEQ) || (op == OP_BNE);
        is_bne = (op == OP_BNE);
        rs     = instr[RS_LSB +: RIDX_W];
        rt     = instr[RT_LSB +: RIDX_W];
        offset = instr[OFF_W-1:0];
    end
endmodule

// File: rtl/brfe_cmp.sv
`timescale 1ns/1ps
module brfe_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ne_sel,
    output logic         taken
);
    logic same;

    always_comb begin
        same  = ~|(a ^ b);
        taken = ne_sel ? ~same : same;
    end
endmodule

// File: rtl/brfe_target.sv
`timescale 1ns/1ps
module brfe_target
    import brfe_pkg::*;
(
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] offset,
    output logic [PC_W-1:0]  target
);
    localparam int EXT_W = PC_W - OFF_W - 2;

    logic [PC_W-1:0] disp;

    always_comb begin
        disp   = {{EXT_W{offset[OFF_W-1]}}, offset, 2'b00};
        target = pc + PC_W'(4) + disp;
    end
endmodule

// File: rtl/brfe_top.sv
`timescale 1ns/1ps
module brfe_top
    import brfe_pkg::*;
#(
    parameter logic [PC_W-1:0] RESET_PC = '0,
    parameter br_mode_e        BR_MODE  = MODE_FLUSH
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [PC_W-1:0]   imem_addr,
    input  logic [ILEN-1:0]   imem_data,
    output logic [RIDX_W-1:0] rs_idx,
    output logic [RIDX_W-1:0] rt_idx,
    input  logic [XLEN-1:0]   rs_val,
    input  logic [XLEN-1:0]   rt_val,
    output logic              squash,
    output logic              hold,
    output logic              ret_valid,
    output logic [PC_W-1:0]   ret_pc,
    output logic [ILEN-1:0]   ret_instr
);
    fe_state_t st_q, st_d;

    logic              id_br, id_bne, id_is_br, id_taken, raw_dep;
    logic [RIDX_W-1:0] id_rs, id_rt, ex_dst;
    logic [OFF_W-1:0]  id_off;
    logic [PC_W-1:0]   id_tgt;

    brfe_decode u_dec (
        .instr  (st_q.ifid.instr),
        .is_br  (id_br),
        .is_bne (id_bne),
        .rs     (id_rs),
        .rt     (id_rt),
        .offset (id_off)
    );

    brfe_cmp #(.W(XLEN)) u_cmp (
        .a      (rs_val),
        .b      (rt_val),
        .ne_sel (id_bne),
        .taken  (id_taken)
    );

    brfe_target u_tgt (
        .pc     (st_q.ifid.pc),
        .offset (id_off),
        .target (id_tgt)
    );

    always_comb begin
        id_is_br = st_q.ifid.valid && id_br;
        ex_dst   = dest_reg(st_q.idex.instr);
        raw_dep  = st_q.idex.valid && (ex_dst != '0)
                && ((ex_dst == id_rs) || (ex_dst == id_rt));
    end

    always_comb begin
        st_d   = st_q;
        squash = 1'b0;
        hold   = 1'b0;

        // straight-line advance
        st_d.pc          = st_q.pc + PC_W'(4);
        st_d.ifid.valid  = 1'b1;
        st_d.ifid.pc     = st_q.pc;
        st_d.ifid.instr  = imem_data;
        st_d.idex.valid  = st_q.ifid.valid;
        st_d.idex.pc     = st_q.ifid.pc;
        st_d.idex.instr  = st_q.ifid.instr;
        st_d.idex.is_br  = id_is_br;
        st_d.idex.taken  = id_taken;
        st_d.idex.target = id_tgt;
        st_d.exmem.valid = st_q.idex.valid;
        st_d.exmem.pc    = st_q.idex.pc;
        st_d.exmem.instr = st_q.idex.instr;
        st_d.memwb       = st_q.exmem;

        if (id_is_br && raw_dep) begin
            hold    = 1'b1;
            st_d.pc   = st_q.pc;
            st_d.ifid = st_q.ifid;
            st_d.idex = '0;
        end else if (id_is_br) begin
            case (BR_MODE)
                MODE_FLUSH: begin
                    if (id_taken) begin
                        st_d.pc   = id_tgt;
                        st_d.ifid = '0;
                        squash    = 1'b1;
                    end
                end
                MODE_DELAY: begin
                    if (id_taken) st_d.pc = id_tgt;
                end
                default: begin
                    st_d.pc   = st_q.pc;
                    st_d.ifid = '0;
                    squash    = 1'b1;
                end
            endcase
        end

        if ((BR_MODE == MODE_EXEC) && st_q.idex.valid && st_q.idex.is_br) begin
            st_d.pc   = st_q.idex.taken ? st_q.idex.target : st_q.pc;
            st_d.ifid = '0;
            squash    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.pc <= RESET_PC;
        end else begin
            st_q <= st_d;
        end
    end

    assign imem_addr = st_q.pc;
    assign rs_idx    = id_rs;
    assign rt_idx    = id_rt;
    assign ret_valid = st_q.memwb.valid;
    assign ret_pc    = st_q.memwb.pc;
    assign ret_instr = st_q.memwb.instr;

endmodule

// File: rtl/brfe_checker.sv
`timescale 1ns/1ps
module brfe_checker
    import brfe_pkg::*;
#(
    parameter logic [PC_W-1:0] RESET_PC = '0,
    parameter br_mode_e        BR_MODE  = MODE_FLUSH
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] imem_addr,
    input logic            squash,
    input logic            hold,
    input logic            ret_valid,
    input logic [PC_W-1:0] ret_pc
);
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (imem_addr == RESET_PC) && !ret_valid);

    a_r4_squash_leaves_gap: assert property (@(posedge clk) disable iff (!rst_n)
        squash |-> ##4 !ret_valid);

    a_r6_delay_never_squashes: assert property (@(posedge clk) disable iff (!rst_n)
        (BR_MODE == MODE_DELAY) |-> !squash);

    a_r8_hold_freezes_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(imem_addr));

    a_r8_hold_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !hold);

    a_r8_hold_leaves_gap: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> ##3 !ret_valid);

    a_r2_retire_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> (ret_pc[1:0] == 2'b00));
endmodule

bind brfe_top brfe_checker #(.RESET_PC(RESET_PC), .BR_MODE(BR_MODE)) i_brfe_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .imem_addr (imem_addr),
    .squash    (squash),
    .hold      (hold),
    .ret_valid (ret_valid),
    .ret_pc    (ret_pc)
);

// File: tb/test_brfe_top.sv
`timescale 1ns/1ps
module test_brfe_top;
    import brfe_pkg::*;

    localparam int NE   = 20;
    localparam int NCYC = 110;
    localparam int HW   = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [31:0] mem [0:63];

    logic [31:0] addr_w [3];
    logic [31:0] data_w [3];
    logic [31:0] rsv_w  [3];
    logic [31:0] rtv_w  [3];
    logic [4:0]  rsi_w  [3];
    logic [4:0]  rti_w  [3];
    logic        sq_w   [3];
    logic        hd_w   [3];
    logic        rv_w   [3];
    logic [31:0] rpc_w  [3];
    logic [31:0] rin_w  [3];

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    function automatic logic [31:0] fetch_word(input logic [31:0] a);
        return (a[31:8] == 24'd0) ? mem[a[7:2]] : 32'd0;
    endfunction

    function automatic logic [31:0] reg_val(input logic [4:0] i);
        return (i == 5'd9) ? 32'd5 : {27'd0, i};
    endfunction

    for (genvar g = 0; g < 3; g++) begin : g_env
        assign data_w[g] = fetch_word(addr_w[g]);
        assign rsv_w[g]  = reg_val(rsi_w[g]);
        assign rtv_w[g]  = reg_val(rti_w[g]);
    end

    brfe_top #(.BR_MODE(MODE_FLUSH)) i_brfe_top (
        .clk(clk), .rst_n(rst_n), .imem_addr(addr_w[0]), .imem_data(data_w[0]),
        .rs_idx(rsi_w[0]), .rt_idx(rti_w[0]), .rs_val(rsv_w[0]), .rt_val(rtv_w[0]),
        .squash(sq_w[0]), .hold(hd_w[0]), .ret_valid(rv_w[0]), .ret_pc(rpc_w[0]),
        .ret_instr(rin_w[0]));

    brfe_top #(.BR_MODE(MODE_DELAY)) i_brfe_top_dly (
        .clk(clk), .rst_n(rst_n), .imem_addr(addr_w[1]), .imem_data(data_w[1]),
        .rs_idx(rsi_w[1]), .rt_idx(rti_w[1]), .rs_val(rsv_w[1]), .rt_val(rtv_w[1]),
        .squash(sq_w[1]), .hold(hd_w[1]), .ret_valid(rv_w[1]), .ret_pc(rpc_w[1]),
        .ret_instr(rin_w[1]));

    brfe_top #(.BR_MODE(MODE_EXEC)) i_brfe_top_exe (
        .clk(clk), .rst_n(rst_n), .imem_addr(addr_w[2]), .imem_data(data_w[2]),
        .rs_idx(rsi_w[2]), .rt_idx(rti_w[2]), .rs_val(rsv_w[2]), .rt_val(rtv_w[2]),
        .squash(sq_w[2]), .hold(hd_w[2]), .ret_valid(rv_w[2]), .ret_pc(rpc_w[2]),
        .ret_instr(rin_w[2]));

    // cycle counter and retire monitor
    int cyc;
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    int          nlog [3];
    logic [31:0] lpc  [3][NE];
    int          lcy  [3][NE];
    logic [4:0]  lrs  [3][NE];
    logic [4:0]  hrs  [3][HW];
    bit          sq_seen [3];

    always @(negedge clk) begin
        for (int g = 0; g < 3; g++) begin
            if (!rst_n) begin
                nlog[g]    = 0;
                sq_seen[g] = 1'b0;
            end else begin
                if (sq_w[g]) sq_seen[g] = 1'b1;
                if (cyc < HW) hrs[g][cyc] = rsi_w[g];
                if (rv_w[g] && nlog[g] < NE) begin
                    lpc[g][nlog[g]] = rpc_w[g];
                    lcy[g][nlog[g]] = cyc;
                    lrs[g][nlog[g]] = rin_w[g][25:21];
                    nlog[g] = nlog[g] + 1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // instruction encoders
    function automatic logic [31:0] alu(input int rd, input int rs, input int rt);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 11'h020};
    endfunction
    function automatic logic [31:0] imm(input int rt, input int rs, input int k);
        return {6'h08, 5'(rs), 5'(rt), 16'(k)};
    endfunction
    function automatic logic [31:0] bra(input bit ne, input int rs, input int rt, input int off);
        return {ne ? 6'h05 : 6'h04, 5'(rs), 5'(rt), 16'(off)};
    endfunction

    // reference model built from the requirements
    logic [31:0] exp_pc [NE];
    int          exp_cy [NE];

    function automatic logic [4:0] ref_dest(input logic [31:0] w);
        if (w[31:26] == 6'h00) return w[15:11];
        if (w[31:26] == 6'h08) return w[20:16];
        return 5'd0;
    endfunction

    task automatic build_ref(input int mode);
        logic [31:0] pc, w, prev_w, tgt, redir;
        bit prev_br, prev_tk, redir_v, br, tk;
        logic [4:0] d;
        int gap;
        pc = 32'd0; redir_v = 1'b0; prev_br = 1'b0; prev_tk = 1'b0; prev_w = 32'd0;
        for (int k = 0; k < NE; k++) begin
            w  = fetch_word(pc);
            br = (w[31:26] == 6'h04) || (w[31:26] == 6'h05);
            tk = (reg_val(w[25:21]) == reg_val(w[20:16])) ^ (w[31:26] == 6'h05);
            exp_pc[k] = pc;
            if (k == 0) exp_cy[k] = 4;
            else begin
                gap = 1;
                d = ref_dest(prev_w);
                if (br && d != 5'd0 && (d == w[25:21] || d == w[20:16])) gap++;
                if (prev_br && mode == 0 && prev_tk) gap++;
                if (prev_br && mode == 2) gap += 2;
                exp_cy[k] = exp_cy[k-1] + gap;
            end
            tgt = pc + 32'd4 + {{14{w[15]}}, w[15:0], 2'b00};
            if (redir_v) begin
                redir_v = 1'b0;
                pc = redir;
            end else if (br && mode == 1) begin
                redir   = tk ? tgt : pc + 32'd8;
                redir_v = 1'b1;
                pc = pc + 32'd4;
            end else if (br && tk) begin
                pc = tgt;
            end else begin
                pc = pc + 32'd4;
            end
            prev_br = br; prev_tk = tk; prev_w = w;
        end
    endtask

    task automatic run_program();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        repeat (NCYC) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic compare_all(input string tag);
        string rq;
        for (int g = 0; g < 3; g++) begin
            build_ref(g);
            rq = (g == 0) ? "R4 R5" : (g == 1) ? "R6" : "R7";
            check(nlog[g] == NE, "R3", {tag, " retire count"}, nlog[g], NE);
            for (int k = 0; k < NE; k++) begin
                if (k < nlog[g]) begin
                    check(lpc[g][k] == exp_pc[k], {"R2 R3 ", rq},
                          $sformatf("%s mode%0d pc order #%0d", tag, g, k), lpc[g][k], exp_pc[k]);
                    check(lcy[g][k] == exp_cy[k], {"R8 R9 ", rq},
                          $sformatf("%s mode%0d retire cycle #%0d", tag, g, k), lcy[g][k], exp_cy[k]);
                    if (lcy[g][k] >= 3 && lcy[g][k] - 3 < HW)
                        check(hrs[g][lcy[g][k]-3] == lrs[g][k], "R10",
                              $sformatf("%s mode%0d rs index #%0d", tag, g, k),
                              hrs[g][lcy[g][k]-3], lrs[g][k]);
                end
            end
        end
        check(sq_seen[1] == 1'b0, "R6", {tag, " delay mode squash"}, sq_seen[1], 0);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        for (int g = 0; g < 3; g++) begin
            check(addr_w[g] == 32'd0, "R1", $sformatf("mode%0d reset addr", g), addr_w[g], 0);
            check(rv_w[g] == 1'b0, "R1", $sformatf("mode%0d reset retire", g), rv_w[g], 0);
            check(rsi_w[g] == 5'd0 && rti_w[g] == 5'd0, "R1",
                  $sformatf("mode%0d reset indices", g), {rsi_w[g], rti_w[g]}, 0);
        end
    endtask

    // forward taken beq (after rd interlock), not-taken bne, taken bne
    task automatic test_prog_fwd();
        for (int i = 0; i < 64; i++) mem[i] = 32'd0;
        mem[0] = alu(1, 2, 3);
        mem[1] = alu(5, 1, 2);
        mem[2] = bra(1'b0, 5, 9, 2);
        mem[3] = alu(3, 0, 0);
        mem[4] = alu(4, 0, 0);
        mem[5] = bra(1'b1, 4, 4, 3);
        mem[6] = alu(6, 0, 0);
        mem[7] = bra(1'b1, 3, 4, 1);
        mem[8] = alu(7, 0, 0);
        mem[9] = alu(8, 0, 0);
        run_program();
        compare_all("fwd");
    endtask

    // backward taken loop with rt-destination interlock every pass
    task automatic test_prog_loop();
        for (int i = 0; i < 64; i++) mem[i] = 32'd0;
        mem[0] = imm(4, 0, 1);
        mem[1] = bra(1'b0, 4, 4, -2);
        mem[2] = alu(9, 1, 2);
        run_program();
        compare_all("loop");
    endtask

    initial begin
        test_reset();
        test_prog_fwd();
        test_prog_loop();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R3 watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule